// File: doc/BRIEF.md
# Receive Character Buffer with Per-Entry Error Tags and Idle Timeout

This block sits between a serial receive engine and the host-facing register decode. Each received byte arrives with three error tags. The block keeps the byte and its tags together as one 11-bit entry in a circular store. The oldest entry is always shown to the host: its data on `head_data` and its tags on `head_err`. The register decode maps `head_err` onto line-status bits 2 to 4. When the host strobes `host_pop`, the head advances, and both outputs show the next entry in the cycle after the strobe.

Two interrupt sources come out of the block:

- **Data interrupt.** In buffered mode it is raised once the fill level reaches a selectable trigger level. In single-entry mode it is raised as soon as one character is waiting.
- **Timeout interrupt.** It is raised when data has been waiting with no new arrival and no host read for four character lengths plus twelve bit times. This makes sure a partial batch below the trigger level still reaches the host.

The input side is a valid-only stream with no back-pressure, because a serial receiver cannot be stalled. A beat offered while the store is full is discarded, and the sticky `overrun` flag is set. The host side is a plain read strobe.

Top module: `rx_holding_fifo`

## Requirements
- R1: Entries leave in arrival order. `head_data` shows the oldest byte, and `head_err` shows that byte's three tags with their bit order unchanged (`wr_err[0]` appears on `head_err[0]`).
- R2: A `host_pop` pulse while the store is non-empty removes the head entry. From the next cycle, `head_data` and `head_err` show the following entry.
- R3: With `fifo_mode`=1 the store holds DEPTH entries (64 by default). A `wr_valid` beat while full is dropped and sets `overrun`. `overrun` stays set until an `ovr_clr` pulse.
- R4: With `fifo_mode`=0 the store holds a single entry, and a second beat is dropped with `overrun` set. Any change of `fifo_mode` empties the store. Beats offered in the cycle of the change are ignored.
- R5: `data_ready` is 1 exactly when at least one entry is stored.
- R6: `data_irq` requires `irq_en`=1.
  - With `fifo_mode`=1 it is high while the fill level is at least the trigger level. The trigger level is chosen by `trig_sel`: 00 gives 1, 01 gives DEPTH/8 (8), 10 gives DEPTH/4 (16), 11 gives DEPTH-8 (56).
  - With `fifo_mode`=0 it is high while an entry is stored.
- R7: While data is stored, `timeout_irq` rises after (4·W+12)·TICKS_PER_BIT `baud_tick` pulses with no write or pop. W is the word length: `word_len` 00, 01, 10 and 11 give 5, 6, 7 and 8 bits, and TICKS_PER_BIT defaults to 16. The output is gated by `irq_en`.
- R8: An accepted write or an accepted pop restarts the timeout count and clears a pending timeout. No timeout builds up while the store is empty.
- R9: A `host_pop` on an empty store moves nothing. `head_data` keeps the last byte removed, and `head_err` reads 000.
- R10: After reset the store is empty and in single-entry mode. `head_data`, `head_err`, `overrun`, `data_irq` and `timeout_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Receive engine offers a character this cycle |
| wr_data | input | 8 | Received byte |
| wr_err | input | 3 | Error tags of the received byte |
| fifo_mode | input | 1 | 1 = buffered mode, 0 = single-entry holding register |
| trig_sel | input | 2 | Trigger level select |
| word_len | input | 2 | Character word length select (5 to 8 bits) |
| baud_tick | input | 1 | Oversampling tick, TICKS_PER_BIT per bit time |
| irq_en | input | 1 | Receive interrupt enable |
| host_pop | input | 1 | Host read strobe on the holding register |
| ovr_clr | input | 1 | Clears the overrun flag |
| head_data | output | 8 | Holding register: oldest byte |
| head_err | output | 3 | Error tags of the head entry |
| data_ready | output | 1 | Store non-empty |
| overrun | output | 1 | Sticky overrun flag |
| data_irq | output | 1 | Receive data interrupt |
| timeout_irq | output | 1 | Receive idle-timeout interrupt |

## Verification
The bench fills the store to exactly DEPTH and then offers one more beat. A design that wrapped its pointers would overwrite the oldest entry, and the drain order would show it. The bench walks every trigger level one entry below and then at the threshold, which catches off-by-one comparisons and a mis-decoded select. It counts timeout ticks one short of the limit and then exactly at it for two word lengths, and restarts the count mid-way with a new write, so a counter that is not restarted or uses the wrong word length fires early or late. It also pops an empty store and switches modes with data held, which exposes pointer slips, garbage on the holding register, and stale entries that survive the switch.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned RXF_DATA_W = 8;
  localparam int unsigned RXF_TAG_W  = 3;

  typedef struct packed {
    logic [RXF_TAG_W-1:0]  tags;
    logic [RXF_DATA_W-1:0] data;
  } rx_entry_t;

  // Fill threshold chosen by the 2-bit select, scaled to the store depth.
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'b00:   return 1;
      2'b01:   return depth / 8;
      2'b10:   return depth / 4;
      default: return depth - 8;
    endcase
  endfunction

  // Idle limit in baud ticks: four words plus twelve bits.
  function automatic int unsigned idle_limit(input logic [1:0] wl, input int unsigned ticks);
    int unsigned bits;
    bits = 4 * (int'(wl) + 5) + 12;
    return bits * ticks;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fifo_mode,
  input  logic                  wr_valid,
  input  rx_entry_t             wr_entry,
  input  logic                  pop,
  input  logic                  ovr_clr,
  output logic [RXF_DATA_W-1:0] head_data,
  output logic [RXF_TAG_W-1:0]  head_err,
  output logic                  empty,
  output logic [CNT_W-1:0]      count,
  output logic                  overrun,
  output logic                  wr_accept,
  output logic                  pop_accept,
  output logic                  flush,
  output logic                  mode_q
);
  rx_entry_t               mem [DEPTH];
  logic [PTR_W-1:0]        wr_ptr, rd_ptr;
  logic [RXF_DATA_W-1:0]   last_q;
  logic [CNT_W-1:0]        cap;
  logic                    full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign flush      = (fifo_mode != mode_q);
  assign cap        = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full       = (count >= cap);
  assign empty      = (count == '0);
  assign wr_accept  = wr_valid && !full && !flush;
  assign pop_accept = pop && !empty && !flush;

  assign head_data  = empty ? last_q : mem[rd_ptr].data;
  assign head_err   = empty ? '0 : mem[rd_ptr].tags;

  always_ff @(posedge clk) begin
    if (wr_accept) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      last_q <= '0;
    end else if (flush) begin
      mode_q <= fifo_mode;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_accept) wr_ptr <= bump(wr_ptr);
      if (pop_accept) begin
        rd_ptr <= bump(rd_ptr);
        last_q <= mem[rd_ptr].data;
      end
      case ({wr_accept, pop_accept})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             overrun <= 1'b0;
    else if (wr_valid && full && !flush)    overrun <= 1'b1;
    else if (ovr_clr)                       overrun <= 1'b0;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_overrun_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !flush) |=> overrun);
  assert_single_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> count <= CNT_W'(1));
  assert_pop_shrinks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_accept && !wr_accept) |=> count == $past(count) - 1'b1);
  assert_empty_pop_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !wr_valid && !flush) |=> $stable(head_data));
endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout
  import rxf_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16,
  localparam int unsigned TO_W = $clog2(44 * TICKS_PER_BIT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] word_len,
  input  logic       active,
  input  logic       restart,
  output logic       to_flag
);
  logic [TO_W-1:0] cnt;
  logic [TO_W-1:0] limit;

  assign limit = TO_W'(idle_limit(word_len, TICKS_PER_BIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      to_flag <= 1'b0;
    end else if (restart || !active) begin
      cnt     <= '0;
      to_flag <= 1'b0;
    end else if (baud_tick && !to_flag) begin
      if (cnt == limit - 1'b1) begin
        cnt     <= '0;
        to_flag <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_timeout_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag |-> active);
  assert_timeout_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag) |-> $past(baud_tick));
  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !to_flag);
endmodule

// File: rtl/rxf_irq.sv
module rxf_irq
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             mode_q,
  input  logic [1:0]       trig_sel,
  input  logic             irq_en,
  input  logic             to_flag,
  output logic             data_irq,
  output logic             timeout_irq
);
  logic [CNT_W-1:0] level;

  assign level       = mode_q ? CNT_W'(trig_level(trig_sel, DEPTH)) : CNT_W'(1);
  assign data_irq    = irq_en && (count >= level);
  assign timeout_irq = irq_en && to_flag;

  assert_irq_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_irq |-> count != '0);
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_irq || timeout_irq) |-> irq_en);
endmodule

// File: rtl/rx_holding_fifo.sv
module rx_holding_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH         = 64,
  parameter int unsigned TICKS_PER_BIT = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic [2:0] wr_err,
  input  logic       fifo_mode,
  input  logic [1:0] trig_sel,
  input  logic [1:0] word_len,
  input  logic       baud_tick,
  input  logic       irq_en,
  input  logic       host_pop,
  input  logic       ovr_clr,
  output logic [7:0] head_data,
  output logic [2:0] head_err,
  output logic       data_ready,
  output logic       overrun,
  output logic       data_irq,
  output logic       timeout_irq
);
  rx_entry_t        wr_entry;
  logic [CNT_W-1:0] count;
  logic             empty, wr_accept, pop_accept, flush, mode_q, to_flag;

  assign wr_entry   = '{tags: wr_err, data: wr_data};
  assign data_ready = !empty;

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk, .rst_n, .fifo_mode, .wr_valid, .wr_entry,
    .pop(host_pop), .ovr_clr, .head_data, .head_err, .empty, .count,
    .overrun, .wr_accept, .pop_accept, .flush, .mode_q
  );

  rxf_timeout #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timeout (
    .clk, .rst_n, .baud_tick, .word_len, .active(!empty),
    .restart(wr_accept || pop_accept || flush), .to_flag
  );

  rxf_irq #(.DEPTH(DEPTH)) u_irq (
    .clk, .rst_n, .count, .mode_q, .trig_sel, .irq_en, .to_flag,
    .data_irq, .timeout_irq
  );

  assert_ready_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !pop_accept) |=> data_ready);
endmodule

// File: tb/rx_holding_fifo_bench.sv
module rx_holding_fifo_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_err = '0;
  logic       fifo_mode = 1'b0;
  logic [1:0] trig_sel = '0;
  logic [1:0] word_len = '0;
  logic       baud_tick = 1'b0;
  logic       irq_en = 1'b0;
  logic       host_pop = 1'b0;
  logic       ovr_clr = 1'b0;
  logic [7:0] head_data;
  logic [2:0] head_err;
  logic       data_ready, overrun, data_irq, timeout_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rx_holding_fifo u_rx_holding_fifo (
    .clk, .rst_n, .wr_valid, .wr_data, .wr_err, .fifo_mode, .trig_sel,
    .word_len, .baud_tick, .irq_en, .host_pop, .ovr_clr, .head_data,
    .head_err, .data_ready, .overrun, .data_irq, .timeout_irq
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(input int d, input int e);
    wr_valid = 1'b1; wr_data = 8'(d); wr_err = 3'(e);
    step();
    wr_valid = 1'b0;
  endtask

  task automatic pop1();
    host_pop = 1'b1;
    step();
    host_pop = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      baud_tick = 1'b1;
      step();
    end
    baud_tick = 1'b0;
  endtask

  task automatic drain();
    while (data_ready) pop1();
  endtask

  task automatic set_mode(input logic m);
    fifo_mode = m;
    step(); step();
  endtask

  task automatic t_reset();
    chk("R10", "data_ready", int'(data_ready), 0);
    chk("R10", "head_data", int'(head_data), 0);
    chk("R10", "head_err", int'(head_err), 0);
    chk("R10", "overrun", int'(overrun), 0);
    chk("R10", "irqs", int'({data_irq, timeout_irq}), 0);
  endtask

  task automatic t_order();
    set_mode(1'b1);
    trig_sel = 2'b00;
    push(8'h5A, 3'b001);
    push(8'hC3, 3'b100);
    push(8'h0F, 3'b010);
    chk("R5", "data_ready after writes", int'(data_ready), 1);
    chk("R1", "head byte", int'(head_data), 8'h5A);
    chk("R1", "head tags", int'(head_err), 3'b001);
    pop1();
    chk("R2", "second byte after pop", int'(head_data), 8'hC3);
    chk("R2", "second tags after pop", int'(head_err), 3'b100);
    pop1();
    chk("R2", "third tags", int'(head_err), 3'b010);
    pop1();
    chk("R5", "data_ready when empty", int'(data_ready), 0);
    pop1();
    chk("R9", "empty pop keeps last byte", int'(head_data), 8'h0F);
    chk("R9", "empty tags read zero", int'(head_err), 0);
    push(8'h77, 3'b111);
    chk("R9", "pointers unmoved by empty pop", int'(head_data), 8'h77);
    drain();
  endtask

  task automatic t_full();
    for (int i = 0; i < 64; i++) push(i, i % 8);
    chk("R3", "no overrun at exactly full", int'(overrun), 0);
    push(8'hAA, 3'b111);
    chk("R3", "overrun after extra beat", int'(overrun), 1);
    for (int i = 0; i < 64; i++) begin
      if (head_data != 8'(i) || head_err != 3'(i % 8))
        chk("R3", "drain order", int'(head_data), i);
      pop1();
    end
    chk("R3", "dropped beat not stored", int'(data_ready), 0);
    chk("R3", "overrun sticky", int'(overrun), 1);
    ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
    chk("R3", "overrun cleared", int'(overrun), 0);
  endtask

  task automatic t_trigger();
    int lvl [4] = '{1, 8, 16, 56};
    irq_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int i = 0; i < lvl[s] - 1; i++) push(i, 0);
      chk("R6", $sformatf("irq below level sel=%0d", s), int'(data_irq), 0);
      push(8'h99, 0);
      chk("R6", $sformatf("irq at level sel=%0d", s), int'(data_irq), 1);
      irq_en = 1'b0; #1;
      chk("R6", "irq gated by enable", int'(data_irq), 0);
      irq_en = 1'b1;
      drain();
    end
  endtask

  task automatic t_single();
    set_mode(1'b0);
    irq_en = 1'b1;
    trig_sel = 2'b11;
    push(8'h11, 3'b101);
    chk("R6", "single mode irq per char", int'(data_irq), 1);
    push(8'h22, 3'b000);
    chk("R4", "second beat overruns", int'(overrun), 1);
    chk("R4", "holding keeps first", int'(head_data), 8'h11);
    pop1();
    chk("R4", "single entry only", int'(data_ready), 0);
    ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
    push(8'h33, 3'b011);
    set_mode(1'b1);
    chk("R4", "mode change flushes", int'(data_ready), 0);
  endtask

  task automatic t_timeout();
    irq_en = 1'b1;
    trig_sel = 2'b11;
    word_len = 2'b00;                 // 32 bits * 16 = 512 ticks
    ticks(1000);
    chk("R8", "no timeout while empty", int'(timeout_irq), 0);
    push(8'h01, 0);
    ticks(511);
    chk("R7", "5-bit one tick short", int'(timeout_irq), 0);
    ticks(1);
    chk("R7", "5-bit at limit", int'(timeout_irq), 1);
    irq_en = 1'b0; #1;
    chk("R7", "timeout gated", int'(timeout_irq), 0);
    irq_en = 1'b1;
    push(8'h02, 0);
    chk("R8", "write clears timeout", int'(timeout_irq), 0);
    ticks(400);
    push(8'h03, 0);
    ticks(511);
    chk("R8", "restart after write", int'(timeout_irq), 0);
    ticks(1);
    chk("R8", "fires after restart", int'(timeout_irq), 1);
    pop1();
    chk("R8", "pop clears timeout", int'(timeout_irq), 0);
    drain();
    word_len = 2'b11;                 // 44 bits * 16 = 704 ticks
    push(8'h04, 0);
    ticks(703);
    chk("R7", "8-bit one tick short", int'(timeout_irq), 0);
    ticks(1);
    chk("R7", "8-bit at limit", int'(timeout_irq), 1);
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_order();
    t_full();
    t_trigger();
    t_single();
    t_timeout();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule